// File: doc/BRIEF.md
# Strided Sample Capture Buffer

This block takes in a continuous stream of converter samples, at most one per clock, and stores one frame of them in an on-chip dual-port memory. The samples are stored in transposed order. A write address generator puts each accepted sample a fixed stride beyond the previous one. When a pass reaches its last slot, the generator moves the start offset up by one and begins the next pass. The whole frame fills every word of the memory exactly once.

After the final word is written, a registered done flag rises and the capture side stops accepting samples. Downstream logic then reads stored words through a simple read port with one cycle of latency. The memory is read on every cycle and the read path has no multiplexer after it. While the done flag is low, the read address is forced to word 0, so a stale address never reaches the memory. A start/clear pulse re-arms the block for a new frame.

Top module: `strided_capture_buf`

## Requirements
- R1: The first accepted sample of a frame is stored at address 0. Within a pass, each accepted sample is stored STRIDE (default 20) addresses above the previous one.
- R2: A pass with offset o covers addresses o, o+STRIDE, ..., o+STRIDE*(PER_PASS-1), which is o+2000 by default. The next sample then goes to o+1. With defaults, a frame holds 2020 samples and sample k (counting from 0) lands at (k mod 101)*20 + (k div 101).
- R3: A cycle with `smp_valid_i` low writes nothing and does not advance the address.
- R4: `done_o` is low while the frame is incomplete. It is high from the clock edge that writes the last sample of the frame.
- R5: While `done_o` is low, the memory is read at address 0 whatever `rd_addr_i` holds, and `rd_valid_o` stays low.
- R6: While `done_o` is high, the word at `rd_addr_i` appears on `rd_data_o` one cycle later, with `rd_valid_o` high.
- R7: Reading does not change stored contents. Reading the same address again returns the same word.
- R8: A cycle with `start_i` high clears `done_o`, the offset and the address as of the next cycle. A sample presented in that same cycle is not stored. A start in the middle of a frame restarts the frame at address 0.
- R9: Samples presented while `done_o` is high are not stored, and `done_o` stays high.
- R10: After reset, `done_o` and `rd_valid_o` are low and the block is armed to capture a frame from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and read paths |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the capture state and arms a new frame |
| smp_valid_i | input | 1 | Marks `smp_data_i` as a sample to store |
| smp_data_i | input | DATA_W | Sample word |
| rd_addr_i | input | ADDR_W | Read address; used only while done is high |
| done_o | output | 1 | Registered flag: the full frame has been stored |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | Read data belongs to an address presented while done was high |

## Verification
Any fault in the offset or pass counters changes where later samples land. The fault shows up when the whole frame is read back after done, as a word holding the data of some other sample index. Because the expected value is a closed-form function of the address, the first wrong address is pinpointed. A miscounted pass length or frame length moves the cycle in which `done_o` rises. This is checked exactly, one accepted sample before and at the final write. Faults in ignore behaviour (gaps, samples after done, the start cycle) show up as a shift of every following word, or as changed contents on a second full readback.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Number of words in one transposed frame
  function automatic int frame_words(input int stride, input int per_pass);
    return stride * per_pass;
  endfunction

  // Width needed to index a count of n items (at least 1)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sc_addr_gen.sv
module sc_addr_gen #(
  parameter int STRIDE   = 20,
  parameter int PER_PASS = 101,
  parameter int ADDR_W   = 11,
  parameter int OFF_W    = 5,
  parameter int ROW_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              valid_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [ROW_W-1:0]  row_q;
  logic              done_q;
  logic              row_last;
  logic              frame_last;

  assign row_last   = (row_q == ROW_W'(PER_PASS - 1));
  assign frame_last = row_last && (off_q == OFF_W'(STRIDE - 1));
  assign wr_en_o    = valid_i && !done_q && !clear_i;
  assign wr_addr_o  = addr_q;
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      addr_q <= '0;
      off_q  <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_en_o) begin
      if (frame_last) begin
        done_q <= 1'b1;
        addr_q <= '0;
        off_q  <= '0;
        row_q  <= '0;
      end else if (row_last) begin
        row_q  <= '0;
        off_q  <= off_q + 1'b1;
        addr_q <= ADDR_W'(off_q) + 1'b1;
      end else begin
        row_q  <= row_q + 1'b1;
        addr_q <= addr_q + ADDR_W'(STRIDE);
      end
    end
  end

  a_r1_stride_step: assert property (@(posedge clk) disable iff (rst)
    wr_en_o && !row_last |=> wr_addr_o == $past(wr_addr_o) + ADDR_W'(STRIDE));

  a_r2_pass_wrap: assert property (@(posedge clk) disable iff (rst)
    wr_en_o && row_last && !frame_last |=>
      wr_addr_o == $past(wr_addr_o) - ADDR_W'(STRIDE * (PER_PASS - 1)) + 1'b1);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i && !clear_i |=> $stable(wr_addr_o) && $stable(done_o));

  a_r4_done_rise: assert property (@(posedge clk) disable iff (rst)
    wr_en_o && frame_last |=> done_o);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !done_o && wr_addr_o == '0);

  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    done_o && !clear_i |=> done_o && $stable(wr_addr_o));
endmodule

// File: rtl/sc_frame_ram.sv
module sc_frame_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2020,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    rd_data_o <= mem[rd_addr_i];
  end

  a_r2_wr_in_range: assert property (@(posedge clk)
    wr_en_i |-> int'(wr_addr_i) < DEPTH);
endmodule

// File: rtl/strided_capture_buf.sv
module strided_capture_buf #(
  parameter int DATA_W   = 16,
  parameter int STRIDE   = 20,
  parameter int PER_PASS = 101,
  localparam int DEPTH   = sc_pkg::frame_words(STRIDE, PER_PASS),
  localparam int ADDR_W  = sc_pkg::idx_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int OFF_W = sc_pkg::idx_w(STRIDE);
  localparam int ROW_W = sc_pkg::idx_w(PER_PASS);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_sel;

  sc_addr_gen #(
    .STRIDE(STRIDE), .PER_PASS(PER_PASS),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROW_W(ROW_W)
  ) addr_gen_i (
    .clk(clk), .rst(rst), .clear_i(start_i), .valid_i(smp_valid_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .done_o(done_o)
  );

  // Unconditional read: the address is pinned to 0 until capture is complete
  assign rd_sel = done_o ? rd_addr_i : '0;

  sc_frame_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(smp_data_i),
    .rd_addr_i(rd_sel), .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= done_o;
  end

  a_r5_no_valid_early: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> !rd_valid_o);

  a_r6_valid_follows_done: assert property (@(posedge clk) disable iff (rst)
    done_o |=> rd_valid_o);

  a_r9_no_write_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wr_en);
endmodule

// File: tb/strided_capture_buf_tb_top.sv
module strided_capture_buf_tb_top;
  localparam int DW  = 16;
  localparam int STR = 20;
  localparam int PP  = 101;
  localparam int NW  = STR * PP;
  localparam int AW  = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          vld = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] raddr = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  strided_capture_buf #(.DATA_W(DW), .STRIDE(STR), .PER_PASS(PP)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .smp_valid_i(vld), .smp_data_i(din),
    .rd_addr_i(raddr), .done_o(done), .rd_data_o(rdata), .rd_valid_o(rvalid)
  );

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] smp(input int tag, input int k);
    return DW'(tag * 4099 + k * 37 + 5);
  endfunction

  // Sample index stored at address a (R1, R2)
  function automatic int idx_of(input int a);
    return (a % STR) * PP + (a / STR);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Feed n samples of a frame; gap>0 inserts an idle cycle every gap cycles
  task automatic feed(input int tag, input int n, input int gap, input bit watch_done);
    int k = 0;
    int c = 0;
    while (k < n) begin
      c++;
      if (gap > 0 && (c % gap) == 0) begin
        vld = 1'b0;
        din = 16'hDEAD;
      end else begin
        if (watch_done && k == n - 1) check("R4 done low before last", done, 0);
        vld = 1'b1;
        din = smp(tag, k);
        k++;
      end
      tick();
    end
    vld = 1'b0;
  endtask

  task automatic readback(input int tag, input string req);
    int bad = 0;
    for (int a = 0; a < NW; a++) begin
      raddr = AW'(a);
      tick();
      if (rdata != smp(tag, idx_of(a)) || !rvalid) begin
        bad++;
        if (bad < 5)
          $display("FAIL %s addr %0d: actual=%0d/%0d expected=%0d/1", req, a,
                   rdata, rvalid, smp(tag, idx_of(a)));
      end
      n_checks++;
      if (bad > 0 && bad < 5 && (rdata != smp(tag, idx_of(a)) || !rvalid)) n_errors++;
      else if (bad >= 5 && (rdata != smp(tag, idx_of(a)) || !rvalid)) n_errors++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    // R10 reset state
    check("R10 done after reset", done, 0);
    check("R10 rd_valid after reset", rvalid, 0);

    // Frame 1 with idle gaps (R1, R2, R3, R4)
    feed(1, NW, 7, 1'b1);
    check("R4 done at last write", done, 1);
    readback(1, "R1 R2 R3 R6 frame1");

    // Repeat reads of one word (R7)
    raddr = AW'(1234);
    tick();
    check("R7 first read", rdata, smp(1, idx_of(1234)));
    tick();
    check("R7 repeat read", rdata, smp(1, idx_of(1234)));

    // Samples while done is high (R9)
    for (int i = 0; i < 50; i++) begin
      vld = 1'b1;
      din = DW'(16'hBEEF + i);
      tick();
    end
    vld = 1'b0;
    check("R9 done stays high", done, 1);
    readback(1, "R7 R9 reread");

    // Start with a sample on the same cycle (R8), then R5 while capturing
    start = 1'b1;
    vld = 1'b1;
    din = 16'h5A5A;
    tick();
    start = 1'b0;
    vld = 1'b0;
    check("R8 done cleared", done, 0);
    raddr = AW'(1777);
    tick();
    check("R5 forced read of word 0", rdata, smp(1, 0));
    check("R5 rd_valid low", rvalid, 0);

    // Partial frame, then restart mid-frame (R8)
    feed(2, 500, 0, 1'b0);
    check("R8 done low mid-frame", done, 0);
    start = 1'b1;
    vld = 1'b1;
    din = 16'hA5A5;
    tick();
    start = 1'b0;
    vld = 1'b0;
    feed(3, NW, 0, 1'b1);
    check("R4 done after full frame", done, 1);
    readback(3, "R8 restart frame3");

    // Reset in done state (R10)
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R10 done cleared by reset", done, 0);
    tick();
    check("R10 rd_valid cleared by reset", rvalid, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule